// File: doc/BRIEF.md
# Direction-Switched Shared Data FIFO

This block is a single data queue that two agents share: a host port and an adapter port. A direction input picks which side may write and which side may read. When direction is 0, the host fills the queue and the adapter drains it. When direction is 1, the adapter fills it and the host drains it. Each side gets an 8-bit status byte. Bit 7 of that byte is the side's ready flag. What the flag means depends on the direction: on the writing side it means "not full", and on the reading side it means "not empty".

Each side also has a flush level input. While either flush input is high, both ready flags read 0. A 0-to-1 transition on either flush input empties the queue. Accesses that break the rules are refused, and a sticky error output records them. Such accesses are: using the wrong side for the current direction, writing a full queue, reading an empty queue, or any access while a flush is held.

Write and read requests are one-cycle strobes (`*_wr_valid`, `*_rd_valid`). The ready flag is the back-pressure signal. A requester must present a strobe only while its ready flag is high. A strobe presented while ready is low is not held pending. It is dropped and flagged. An accepted read puts the head entry on that side's read-data output one clock later. A refused read puts zero there.

Top module: `xdir_shared_fifo`

## Requirements
- R1: The queue holds DEPTH (default 10) entries of W (default 16) bits and returns them in the order they were written.
- R2: With direction 0, host writes and adapter reads are accepted. Host ready (host_stat bit 7) is 1 exactly when the queue is not full. Adapter ready (adp_stat bit 7) is 1 exactly when it is not empty.
- R3: With direction 1, adapter writes and host reads are accepted. Adapter ready is "not full" and host ready is "not empty". A direction change is reflected in both flags without waiting for a clock edge. Status bit 4 carries the direction.
- R4: A write or read from the side not allowed by the current direction leaves the queue unchanged and sets the error flag. A refused read drives zero on that side's read data.
- R5: A write to a full queue, or a read from an empty one, leaves the queue unchanged, sets the error flag, and (for a read) returns zero.
- R6: While either flush input is high, both ready flags are 0 and every access is refused and flagged.
- R7: A 0-to-1 transition of either flush input empties the queue and clears the error flag at that clock edge.
- R8: The error flag (access_err, also status bit 0) stays set across later cycles, including a flush falling edge, until the next flush rising edge or reset.
- R9: After reset, the queue is empty and the error flag is 0. With direction 0, host ready is 1 and adapter ready is 0.
- R10: In direction 0, a host write and an adapter read in the same cycle are both accepted. The read returns the old head, and the new entry joins the tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | 0: host writes, adapter reads; 1: adapter writes, host reads |
| host_flush | input | 1 | Host flush level |
| adp_flush | input | 1 | Adapter flush level |
| host_wr_valid | input | 1 | Host write strobe |
| host_wr_data | input | W | Host write data |
| host_rd_valid | input | 1 | Host read strobe |
| host_rd_data | output | W | Host read data, updated the cycle after a read strobe |
| adp_wr_valid | input | 1 | Adapter write strobe |
| adp_wr_data | input | W | Adapter write data |
| adp_rd_valid | input | 1 | Adapter read strobe |
| adp_rd_data | output | W | Adapter read data, updated the cycle after a read strobe |
| host_stat | output | 8 | Host status: bit 7 ready, bit 4 direction, bit 0 error |
| adp_stat | output | 8 | Adapter status: bit 7 ready, bit 4 direction, bit 0 error |
| access_err | output | 1 | Sticky illegal-access flag |

## Verification
A wrong occupancy count shows up first in the ready flags. A queue that believes it is full or empty too early drops a ready flag one access before the expected point. That is caught after the tenth write and after the last read. A wrong read pointer shows up as a wrong word on the read data one cycle after the strobe, so the fill-and-drain order is checked word by word. A missed flush edge, or an error flag that clears too early, shows at the edge itself or in the idle cycles after it.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic {
    DIR_H2A = 1'b0,
    DIR_A2H = 1'b1
  } dir_e;

  localparam int STAT_RDY_BIT = 7;
  localparam int STAT_DIR_BIT = 4;
  localparam int STAT_ERR_BIT = 0;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int W     = 16,
  parameter int DEPTH = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= push_data;
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R1: occupancy never exceeds capacity
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R5: the control never pops an empty queue
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R1: a lone push grows the count by one
  p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |=> cnt == $past(cnt) + 1'b1);
  // R7: a clear leaves the queue empty
  p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic host_flush,
  input  logic adp_flush,
  input  logic empty,
  input  logic full,
  input  logic h_wr,
  input  logic h_rd,
  input  logic a_wr,
  input  logic a_rd,
  output logic h_rdy,
  output logic a_rdy,
  output logic h_push,
  output logic a_push,
  output logic h_pop,
  output logic a_pop,
  output logic clr,
  output logic err
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0] fl_now, fl_q, fl_rise;
  logic             fl_any, not_empty, not_full, bad;

  assign fl_now = {adp_flush, host_flush};

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q[s] <= 1'b0;
        else        fl_q[s] <= fl_now[s];
      end
      assign fl_rise[s] = fl_now[s] & ~fl_q[s];
    end
  endgenerate

  assign fl_any    = |fl_now;
  assign clr       = |fl_rise;
  assign not_empty = !empty && !fl_any;
  assign not_full  = !full  && !fl_any;

  assign h_rdy = (dir == DIR_A2H) ? not_empty : not_full;
  assign a_rdy = (dir == DIR_A2H) ? not_full  : not_empty;

  assign h_push = h_wr && (dir == DIR_H2A) && h_rdy;
  assign a_pop  = a_rd && (dir == DIR_H2A) && a_rdy;
  assign a_push = a_wr && (dir == DIR_A2H) && a_rdy;
  assign h_pop  = h_rd && (dir == DIR_A2H) && h_rdy;

  assign bad = (h_wr && !h_push) || (h_rd && !h_pop) ||
               (a_wr && !a_push) || (a_rd && !a_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err <= 1'b0;
    else if (clr) err <= 1'b0;
    else if (bad) err <= 1'b1;
  end

  // R2/R3: at most one side may feed the queue
  p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h_push, a_push}));
  // R6: a held flush blocks every transfer
  p_flush_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_flush || adp_flush) |-> !(h_push || a_push || h_pop || a_pop));
  // R4: a refused access raises the error flag
  p_bad_sets_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !clr) |=> err);
  // R8: error stays until a flush edge
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);
endmodule

// File: rtl/xdir_shared_fifo.sv
module xdir_shared_fifo
  import sdf_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir,
  input  logic         host_flush,
  input  logic         adp_flush,
  input  logic         host_wr_valid,
  input  logic [W-1:0] host_wr_data,
  input  logic         host_rd_valid,
  output logic [W-1:0] host_rd_data,
  input  logic         adp_wr_valid,
  input  logic [W-1:0] adp_wr_data,
  input  logic         adp_rd_valid,
  output logic [W-1:0] adp_rd_data,
  output logic [7:0]   host_stat,
  output logic [7:0]   adp_stat,
  output logic         access_err
);
  logic         h_rdy, a_rdy, h_push, a_push, h_pop, a_pop, clr, err;
  logic         empty, full, push, pop;
  logic [W-1:0] head, push_data;

  sdf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir        (dir),
    .host_flush (host_flush),
    .adp_flush  (adp_flush),
    .empty      (empty),
    .full       (full),
    .h_wr       (host_wr_valid),
    .h_rd       (host_rd_valid),
    .a_wr       (adp_wr_valid),
    .a_rd       (adp_rd_valid),
    .h_rdy      (h_rdy),
    .a_rdy      (a_rdy),
    .h_push     (h_push),
    .a_push     (a_push),
    .h_pop      (h_pop),
    .a_pop      (a_pop),
    .clr        (clr),
    .err        (err)
  );

  assign push      = h_push | a_push;
  assign pop       = h_pop | a_pop;
  assign push_data = h_push ? host_wr_data : adp_wr_data;

  sdf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head      (head),
    .empty     (empty),
    .full      (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rd_data <= '0;
      adp_rd_data  <= '0;
    end else begin
      if (host_rd_valid) host_rd_data <= h_pop ? head : '0;
      if (adp_rd_valid)  adp_rd_data  <= a_pop ? head : '0;
    end
  end

  always_comb begin
    host_stat               = '0;
    host_stat[STAT_RDY_BIT] = h_rdy;
    host_stat[STAT_DIR_BIT] = dir;
    host_stat[STAT_ERR_BIT] = err;
    adp_stat                = '0;
    adp_stat[STAT_RDY_BIT]  = a_rdy;
    adp_stat[STAT_DIR_BIT]  = dir;
    adp_stat[STAT_ERR_BIT]  = err;
  end

  assign access_err = err;

  // R4/R5: a refused host read yields zero
  p_host_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_valid && !h_pop) |=> host_rd_data == '0);
  // R4/R5: a refused adapter read yields zero
  p_adp_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adp_rd_valid && !a_pop) |=> adp_rd_data == '0);
endmodule

// File: tb/sim_xdir_shared_fifo.sv
module sim_xdir_shared_fifo;
  localparam int W = 16;
  localparam int DEPTH = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir = 1'b0, host_flush = 1'b0, adp_flush = 1'b0;
  logic         host_wr_valid = 1'b0, host_rd_valid = 1'b0;
  logic         adp_wr_valid = 1'b0, adp_rd_valid = 1'b0;
  logic [W-1:0] host_wr_data = '0, adp_wr_data = '0;
  logic [W-1:0] host_rd_data, adp_rd_data;
  logic [7:0]   host_stat, adp_stat;
  logic         access_err;

  int total = 0, failed = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xdir_shared_fifo #(.W(W), .DEPTH(DEPTH)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    #1;
    cycles++;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hpush(input logic [W-1:0] d);
    host_wr_valid = 1; host_wr_data = d; tick(); host_wr_valid = 0;
  endtask
  task automatic apush(input logic [W-1:0] d);
    adp_wr_valid = 1; adp_wr_data = d; tick(); adp_wr_valid = 0;
  endtask
  task automatic hpop();
    host_rd_valid = 1; tick(); host_rd_valid = 0;
  endtask
  task automatic apop();
    adp_rd_valid = 1; tick(); adp_rd_valid = 0;
  endtask
  task automatic hflush_pulse();
    host_flush = 1; tick(); host_flush = 0; tick();
  endtask

  task automatic t_reset();
    chk("R9 host ready", host_stat[7], 1);
    chk("R9 adapter ready", adp_stat[7], 0);
    chk("R9 error", access_err, 0);
  endtask

  task automatic t_h2a_fill();
    dir = 0; #1;
    hpush(16'hA000);
    chk("R2 adapter ready after one", adp_stat[7], 1);
    for (int i = 1; i < DEPTH; i++) hpush(16'hA000 + 16'(i));
    chk("R2 host ready full", host_stat[7], 0);
    chk("R2 adapter ready full", adp_stat[7], 1);
    hpush(16'hBEEF);
    chk("R5 write full err", access_err, 1);
    for (int i = 0; i < DEPTH; i++) begin
      apop();
      chk("R1 order", adp_rd_data, 16'hA000 + 16'(i));
    end
    chk("R8 err held", access_err, 1);
    chk("R2 adapter ready empty", adp_stat[7], 0);
    chk("R2 host ready empty", host_stat[7], 1);
    apop();
    chk("R5 read empty zero", adp_rd_data, 0);
    host_flush = 1; tick();
    chk("R7 flush clears err", access_err, 0);
    host_flush = 0; tick();
  endtask

  task automatic t_a2h();
    dir = 1; #1;
    chk("R3 host ready dir1 empty", host_stat[7], 0);
    chk("R3 adapter ready dir1 empty", adp_stat[7], 1);
    chk("R3 dir bit", host_stat[4], 1);
    for (int i = 0; i < 3; i++) apush(16'hB000 + 16'(i));
    chk("R3 host ready nonempty", host_stat[7], 1);
    for (int i = 0; i < 3; i++) begin
      hpop();
      chk("R3 host read", host_rd_data, 16'hB000 + 16'(i));
    end
    for (int i = 0; i < DEPTH; i++) apush(16'h1);
    chk("R3 adapter ready full", adp_stat[7], 0);
    chk("R3 host ready full", host_stat[7], 1);
    chk("R3 no error", access_err, 0);
    adp_flush = 1; tick(); adp_flush = 0; tick();
    chk("R7 adapter flush empties", host_stat[7], 0);
  endtask

  task automatic t_wrong_dir();
    dir = 1; #1;
    apush(16'hC0C0);
    apop();
    chk("R4 wrong-side read zero", adp_rd_data, 0);
    chk("R4 wrong-side read err", access_err, 1);
    hpop();
    chk("R4 queue unchanged", host_rd_data, 16'hC0C0);
    hpush(16'h1234);
    chk("R4 wrong-side write not stored", host_stat[7], 0);
    hflush_pulse();
  endtask

  task automatic t_flush();
    dir = 0; #1;
    for (int i = 0; i < 4; i++) hpush(16'hE000 + 16'(i));
    adp_flush = 1; #1;
    chk("R6 host ready forced", host_stat[7], 0);
    chk("R6 adapter ready forced", adp_stat[7], 0);
    tick();
    hpush(16'h5555);
    chk("R6 access during flush err", access_err, 1);
    tick();
    chk("R8 err sticky", access_err, 1);
    adp_flush = 0; tick();
    chk("R7 emptied adapter ready", adp_stat[7], 0);
    chk("R7 emptied host ready", host_stat[7], 1);
    chk("R8 err after flush fall", access_err, 1);
    hflush_pulse();
    chk("R7 host flush clears err", access_err, 0);
  endtask

  task automatic t_simul();
    dir = 0; #1;
    hpush(16'hD000);
    hpush(16'hD001);
    host_wr_valid = 1; host_wr_data = 16'hD002; adp_rd_valid = 1;
    tick();
    host_wr_valid = 0; adp_rd_valid = 0;
    chk("R10 simultaneous read", adp_rd_data, 16'hD000);
    chk("R10 no error", access_err, 0);
    apop(); chk("R10 second", adp_rd_data, 16'hD001);
    apop(); chk("R10 third", adp_rd_data, 16'hD002);
    chk("R10 empty after", adp_stat[7], 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_h2a_fill();
    t_a2h();
    t_wrong_dir();
    t_flush();
    t_simul();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++;
      failed++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule